// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat memory burst. A load strobe captures a full external address and starts a burst. On each later clock, an active-low advance input either moves to the next beat or keeps the current one. Only the low two address bits take part in the burst. The upper bits stay as they were when the address was loaded.

A mode input selects one of two beat orders. Linear order counts the low bits upward from the starting value and wraps modulo four. Interleaved order XORs the starting low bits with a beat index that runs 0, 1, 2, 3. The address is registered from the load and advance inputs. The mode input acts combinationally on the output.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, `curAddr` is all zeros.
- R2: One clock after `loadEn` is high, `curAddr` equals the `loadAddr` value that was present at that edge, in either mode.
- R3: With `modeInterleave` low (linear), each clock with `advanceN` low and `loadEn` low adds one, modulo 4, to `curAddr[1:0]`. For example, start 1 gives 1, 2, 3, 0.
- R4: With `modeInterleave` high (interleaved), `curAddr[1:0]` equals the loaded low bits XOR a beat index. The beat index is 0 at load and goes up by one on each advance. For example, start 1 gives 1, 0, 3, 2.
- R5: On a clock with `advanceN` high and `loadEn` low, `curAddr` keeps its value.
- R6: `curAddr[ADDR_W-1:2]` changes only on a load. Advances never carry into the upper bits, even from the all-ones address.
- R7: After four advances, `curAddr` returns to the address that was loaded, in both orders.
- R8: When `loadEn` is high and `advanceN` is low on the same edge, the load wins. The burst restarts at beat 0 of the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Starts a burst at `loadAddr` |
| loadAddr | input | ADDR_W | Starting word address |
| advanceN | input | 1 | Low: step to the next beat; high: hold |
| modeInterleave | input | 1 | 1: interleaved order; 0: linear order |
| curAddr | output | ADDR_W | Current burst word address |

## Verification
The bench builds the block with a 16-bit address and a 2-bit beat counter. With those values, a full four-beat wrap is reached in a short vector table. Starting addresses with non-zero low bits separate the linear order from the XOR order. A load at the all-ones address shows that no carry reaches the upper bits.

// File: rtl/burst_pkg.sv
package burst_pkg;
  // Strobes from the control decode to the address datapath
  typedef struct packed {
    logic load;
    logic step;
  } seq_ctl_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import burst_pkg::*;
(
  input  logic     loadEn,
  input  logic     advanceN,
  output seq_ctl_t ctl
);
  // Load has priority (R8); a step happens only without a load
  always_comb begin
    ctl.load = loadEn;
    ctl.step = !loadEn && !advanceN;
  end
endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctl_t          ctl,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] curAddr
);
  localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

  logic [ADDR_W-1:0] baseQ;
  logic [BEAT_W-1:0] beatQ;
  logic [BEAT_W-1:0] lowLin;
  logic [BEAT_W-1:0] lowIlv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      beatQ <= '0;
    end else if (ctl.load) begin
      baseQ <= loadAddr;
      beatQ <= '0;
    end else if (ctl.step) begin
      beatQ <= beatQ + BEAT_ONE;
    end
  end

  always_comb begin
    lowLin  = baseQ[BEAT_W-1:0] + beatQ;
    lowIlv  = baseQ[BEAT_W-1:0] ^ beatQ;
    curAddr = {baseQ[ADDR_W-1:BEAT_W], (modeInterleave ? lowIlv : lowLin)};
  end

  // R2 / R8: a load captures the address and restarts the beat index
  p_load_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (baseQ == $past(loadAddr)) && (beatQ == '0));

  // R3 / R4: a step moves the beat index by exactly one
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> beatQ == BEAT_W'($past(beatQ) + BEAT_ONE));

  // R5: no strobe, no state change
  p_hold_still_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> ($stable(beatQ) && $stable(baseQ)));

  // R6: upper address bits only move on a load
  p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(curAddr[ADDR_W-1:BEAT_W]));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              advanceN,
  input  logic              modeInterleave,
  output logic [ADDR_W-1:0] curAddr
);
  seq_ctl_t ctl;

  seq_ctrl u_ctrl (
    .loadEn   (loadEn),
    .advanceN (advanceN),
    .ctl      (ctl)
  );

  seq_dpath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .loadAddr       (loadAddr),
    .modeInterleave (modeInterleave),
    .curAddr        (curAddr)
  );
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NVEC = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadEn = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic          advanceN = 1'b1;
  logic          modeInterleave = 1'b0;
  logic [AW-1:0] curAddr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .advanceN(advanceN), .modeInterleave(modeInterleave), .curAddr(curAddr)
  );

  // Fields: req[3:0], loadEn, loadAddr[15:0], advanceN, modeInterleave, expected[15:0]
  localparam logic [38:0] VEC [NVEC] = '{
    {4'd2, 1'b1, 16'h1235, 1'b1, 1'b0, 16'h1235}, // R2 linear load
    {4'd3, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h1236}, // R3
    {4'd3, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h1237}, // R3
    {4'd6, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h1234}, // R6 wrap in low bits only
    {4'd7, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h1235}, // R7 back to start
    {4'd5, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h1235}, // R5 hold
    {4'd2, 1'b1, 16'hABC1, 1'b1, 1'b1, 16'hABC1}, // R2 interleaved load
    {4'd4, 1'b0, 16'h0000, 1'b0, 1'b1, 16'hABC0}, // R4
    {4'd4, 1'b0, 16'h0000, 1'b0, 1'b1, 16'hABC3}, // R4
    {4'd4, 1'b0, 16'h0000, 1'b0, 1'b1, 16'hABC2}, // R4
    {4'd7, 1'b0, 16'h0000, 1'b0, 1'b1, 16'hABC1}, // R7
    {4'd5, 1'b0, 16'h0000, 1'b1, 1'b1, 16'hABC1}, // R5
    {4'd8, 1'b1, 16'h00F2, 1'b0, 1'b1, 16'h00F2}, // R8 load beats advance
    {4'd4, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h00F3}, // R4
    {4'd8, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'hFFFF}, // R8
    {4'd6, 1'b0, 16'h0000, 1'b0, 1'b0, 16'hFFFC}  // R6 no carry upward
  };

  task automatic check(input string tag, input logic [AW-1:0] exp);
    checks++;
    if (curAddr !== exp) begin
      errors++;
      $display("FAIL %s: curAddr=%h expected=%h", tag, curAddr, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 in reset", '0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 after release", '0);

    for (int i = 0; i < NVEC; i++) begin
      {loadEn, loadAddr, advanceN, modeInterleave} = VEC[i][34:16];
      @(posedge clk); @(negedge clk);
      check($sformatf("R%0d vector %0d", VEC[i][38:35], i), VEC[i][15:0]);
    end

    // R1: reset in the middle of a burst clears the address
    loadEn = 1'b0; advanceN = 1'b1;
    rstN = 1'b0;
    #1;
    check("R1 mid-run reset", '0);
    @(negedge clk);
    rstN = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule